// File: doc/BRIEF.md
# Four-Channel Pulse Frame Transmitter

This block sends one short frame on each of four coil-drive channels at the same time. The frames share their timing but carry different data. Time is counted in ticks of an external 4 kHz strobe. A frame is built from a 4-bit payload, the low bit of the channel number, a unit-type flag and a program-change flag. It is sent most significant bit first as time slices of 16 ticks each. A parity bit and a closing pulse follow the frame bits.

Ticks are counted in a repeating window of 8192 (about two seconds). Where a transmission starts inside that window is chosen by a 16-bit shift register, which also takes in four bits of outside entropy at each window boundary. Two units that talk to each other therefore stop colliding after a few windows. A busy output covers the whole transmission so that a receiver can be held off during it. Each pulse output is a plain per-channel enable for the coil driver.

Top module: `pulse_frame_tx`

## Requirements
- R1: After reset `pulse_o` and `busy_o` are 0. The block stays idle, with no busy and no pulses, until the tick counter first wraps from 8191 to 0, which is 8192 ticks after reset.
- R2: The frame of channel c is 11 bits, with bit 10 = 1, bit 9 = 0, bit 8 = c[0], bit 7 = `unit_type_i`, bit 6 = `prog_chg_i`, bit 5 = 0, bits 4..1 = the channel's payload (`payload_i[4c+3:4c]`) and bit 0 = 0.
- R3: A slice lasts 16 ticks and a pulse fills a whole slice. Each bit takes four slices: slice 0 always carries a pulse, slice 2 carries a pulse only when the bit is 1, and slices 1 and 3 are always empty.
- R4: Frame bits go out from bit 10 down to bit 0 in slices 0..43. The parity bit uses slices 44..47 and a lone closing pulse fills slice 48, for 49 slices in all.
- R5: The parity bit is the XOR of the 11 frame bits.
- R6: At each wrap the start offset is set to 1024 × the three low bits of the shift register as they stand before that tick. The offset counts from counter value 0 of the new window.
- R7: The shift register starts at 0x0001 after reset. On each tick that is not a wrap it shifts left by one and takes bit15 XOR bit1 XOR bit0 into bit 0. On a wrap tick it shifts left by four and takes `entropy_i` into bits 3..0.
- R8: The first slice starts 12 ticks after the start offset, and no pulse is sent in those 12 ticks.
- R9: `busy_o` is high from the tick that reaches the start offset until the closing slice ends: 12 + 49×16 = 796 ticks.
- R10: The frame contents are captured at the start offset. Changes to payload, unit-type or program-change during a transmission do not change that transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock strobe at 4 kHz |
| payload_i | input | 16 | Four 4-bit payloads, channel c in bits 4c+3..4c |
| unit_type_i | input | 1 | Unit-type flag placed in every frame |
| prog_chg_i | input | 1 | Program-change flag placed in every frame |
| entropy_i | input | 4 | Outside entropy taken in at each wrap |
| pulse_o | output | 4 | Per-channel pulse enable, registered |
| busy_o | output | 1 | Transmission in progress, registered |

## Verification
The bench models the shift register, the window counter and the slice schedule independently, and compares busy and all four pulse lines after every tick across five windows. It goes after these corner cases:
- the first window after reset, where a design that arms at once would transmit too early;
- the 12-tick lead-in, where an off-by-one lead would shift every pulse by a slice;
- the parity and closing slices, where a wrong parity sense or a missing closing pulse would show;
- the start slot itself, where taking the slot after the entropy shift instead of before would move the whole transmission by some multiple of 1024 ticks.

Inputs are also changed in the middle of each transmission. A design that did not hold the frame would then send mixed bits.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam int FRAME_W      = 11;
  localparam int PAY_W        = 4;
  localparam int BIT_SLICES   = 4;
  localparam int FRAME_SLICES = (FRAME_W + 1) * BIT_SLICES + 1;
  typedef logic [FRAME_W-1:0] frame_t;

  function automatic frame_t build_frame(input logic [PAY_W-1:0] pay, input logic gender,
                                         input logic utype, input logic pchg);
    return {1'b1, 1'b0, gender, utype, pchg, 1'b0, pay, 1'b0};
  endfunction
endpackage

// File: rtl/pft_prng.sv
module pft_prng #(
  parameter int LFSR_W = 16,
  parameter int ENT_W  = 4,
  parameter logic [LFSR_W-1:0] SEED = 16'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wrap,
  input  logic [ENT_W-1:0]  entropy,
  output logic [LFSR_W-1:0] lfsr_q
);
  logic fb;
  assign fb = lfsr_q[LFSR_W-1] ^ lfsr_q[1] ^ lfsr_q[0];

  always_ff @(posedge clk) begin
    if (rst)       lfsr_q <= SEED;
    else if (wrap) lfsr_q <= {lfsr_q[LFSR_W-ENT_W-1:0], entropy};
    else if (tick) lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
  end

  assert_entropy_in_R7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> lfsr_q[ENT_W-1:0] == $past(entropy));
  assert_shift_step_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap) |=> lfsr_q[LFSR_W-1:1] == $past(lfsr_q[LFSR_W-2:0]));
endmodule

// File: rtl/pft_seq.sv
module pft_seq
  import pft_pkg::*;
#(
  parameter int CYC_W   = 13,
  parameter int SLOT_W  = 3,
  parameter int SLICE_W = 4,
  parameter int LEAD    = 12,
  localparam int SPAN_W = CYC_W - SLOT_W,
  localparam int WIN    = LEAD + (FRAME_SLICES << SLICE_W),
  localparam int OFS_W  = $clog2(WIN + 1),
  localparam int SLC_W  = $clog2(FRAME_SLICES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [SLOT_W-1:0] slot_pick,
  output logic              wrap_o,
  output logic              launch_o,
  output logic              busy_q,
  output logic              tx_q,
  output logic [SLC_W-1:0]  slice_q
);
  logic [CYC_W-1:0]   ctr_q, ctr_n, start_n;
  logic [SLOT_W-1:0]  slot_q, slot_n;
  logic               armed_q, armed_n;
  logic [OFS_W-1:0]   ofs_q;
  logic [SLICE_W-1:0] sub_q;

  always_comb begin
    ctr_n    = ctr_q + 1'b1;
    wrap_o   = tick && (&ctr_q);
    slot_n   = wrap_o ? slot_pick : slot_q;
    armed_n  = armed_q | wrap_o;
    start_n  = {slot_n, {SPAN_W{1'b0}}};
    launch_o = tick && armed_n && (ctr_n == start_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q <= '0; slot_q <= '0; armed_q <= 1'b0;
    end else if (tick) begin
      ctr_q <= ctr_n; slot_q <= slot_n; armed_q <= armed_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; tx_q <= 1'b0; ofs_q <= '0; sub_q <= '0; slice_q <= '0;
    end else if (launch_o) begin
      busy_q <= 1'b1; tx_q <= 1'b0; ofs_q <= '0;
    end else if (tick && busy_q) begin
      ofs_q <= ofs_q + 1'b1;
      if (ofs_q == OFS_W'(WIN - 1)) begin
        busy_q <= 1'b0; tx_q <= 1'b0;
      end else if (ofs_q == OFS_W'(LEAD - 1)) begin
        tx_q <= 1'b1; sub_q <= '0; slice_q <= '0;
      end else if (tx_q) begin
        sub_q <= sub_q + 1'b1;
        if (&sub_q) slice_q <= slice_q + 1'b1;
      end
    end
  end

  assert_idle_until_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> !busy_q);
  assert_slot_hold_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(slot_q));
  assert_slice_bound_R4: assert property (@(posedge clk) disable iff (rst)
    tx_q |-> (busy_q && slice_q < SLC_W'(FRAME_SLICES)));
endmodule

// File: rtl/pft_lane.sv
module pft_lane
  import pft_pkg::*;
#(
  parameter int SLC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  frame_t           frame_in,
  input  logic             tx,
  input  logic [SLC_W-1:0] slice,
  output logic             pulse_q
);
  frame_t             frame_q, shifted;
  logic [SLC_W-3:0]   bitn;
  logic [1:0]         phase;
  logic               bit_val, pulse_d;

  always_comb begin
    bitn    = slice[SLC_W-1:2];
    phase   = slice[1:0];
    shifted = frame_q << bitn;
    bit_val = (bitn == (SLC_W-2)'(FRAME_W)) ? ^frame_q : shifted[FRAME_W-1];
    pulse_d = tx && ((phase == 2'd0) || (phase == 2'd2 && bit_val));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0; pulse_q <= 1'b0;
    end else begin
      if (launch) frame_q <= frame_in;
      pulse_q <= pulse_d;
    end
  end

  assert_frame_marks_R2: assert property (@(posedge clk) disable iff (rst)
    launch |=> (frame_q[FRAME_W-1] && !frame_q[FRAME_W-2] && !frame_q[5] && !frame_q[0]));
endmodule

// File: rtl/pulse_frame_tx.sv
module pulse_frame_tx
  import pft_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int CYC_W    = 13,
  parameter int SLOT_W   = 3,
  parameter int SLICE_W  = 4,
  parameter int LEAD     = 12,
  parameter int LFSR_W   = 16,
  parameter int ENT_W    = 4,
  localparam int SLC_W   = $clog2(FRAME_SLICES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic [CHANNELS*PAY_W-1:0] payload_i,
  input  logic                      unit_type_i,
  input  logic                      prog_chg_i,
  input  logic [ENT_W-1:0]          entropy_i,
  output logic [CHANNELS-1:0]       pulse_o,
  output logic                      busy_o
);
  logic              wrap, launch, busy_q, tx_q;
  logic [SLC_W-1:0]  slice_q;
  logic [LFSR_W-1:0] lfsr_q;

  pft_prng #(.LFSR_W(LFSR_W), .ENT_W(ENT_W)) u_prng (
    .clk(clk), .rst(rst), .tick(tick), .wrap(wrap), .entropy(entropy_i), .lfsr_q(lfsr_q));

  pft_seq #(.CYC_W(CYC_W), .SLOT_W(SLOT_W), .SLICE_W(SLICE_W), .LEAD(LEAD)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .slot_pick(lfsr_q[SLOT_W-1:0]),
    .wrap_o(wrap), .launch_o(launch), .busy_q(busy_q), .tx_q(tx_q), .slice_q(slice_q));

  for (genvar c = 0; c < CHANNELS; c++) begin : g_lane
    frame_t frm;
    assign frm = build_frame(payload_i[c*PAY_W +: PAY_W], c[0], unit_type_i, prog_chg_i);
    pft_lane #(.SLC_W(SLC_W)) u_lane (
      .clk(clk), .rst(rst), .launch(launch), .frame_in(frm), .tx(tx_q),
      .slice(slice_q), .pulse_q(pulse_o[c]));
  end

  always_ff @(posedge clk) begin
    if (rst) busy_o <= 1'b0;
    else     busy_o <= busy_q;
  end

  assert_pulse_needs_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (|pulse_o) |-> busy_o);
  assert_quiet_lead_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (pulse_o == '0));
endmodule

// File: tb/pulse_frame_tx_bench.sv
`timescale 1ns/1ps
module pulse_frame_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [15:0] payload_i = 16'h0;
  logic        unit_type_i = 1'b0;
  logic        prog_chg_i = 1'b0;
  logic [3:0]  entropy_i = 4'h0;
  logic [3:0]  pulse_o;
  logic        busy_o;

  always #2.5 clk = ~clk;

  pulse_frame_tx u_pulse_frame_tx (
    .clk(clk), .rst(rst), .tick(tick), .payload_i(payload_i), .unit_type_i(unit_type_i),
    .prog_chg_i(prog_chg_i), .entropy_i(entropy_i), .pulse_o(pulse_o), .busy_o(busy_o));

  typedef struct {
    logic       busy;
    logic [3:0] pulse;
    string      tag;
  } item_t;
  item_t sb[$];
  event  chk_ev;
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  // reference model state
  logic [15:0] m_lfsr = 16'h0001;
  int          m_ctr = 0;
  int          m_slot = 0;
  bit          m_armed = 1'b0;
  logic [10:0] m_frame [4];
  int          m_cyc = 0;

  function automatic logic [10:0] mk_frame(int c);
    return {1'b1, 1'b0, c[0], unit_type_i, prog_chg_i, 1'b0, payload_i[c*4 +: 4], 1'b0};
  endfunction

  task automatic model_tick(output item_t it);
    int start, ofs, s, b, ph;
    logic bv;
    it.busy = 1'b0; it.pulse = 4'h0; it.tag = m_armed ? "R9" : "R1";
    if (m_ctr == 8191) begin
      m_slot  = int'(m_lfsr[2:0]);
      m_lfsr  = {m_lfsr[11:0], entropy_i};
      m_armed = 1'b1;
    end else begin
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[1] ^ m_lfsr[0]};
    end
    m_ctr = (m_ctr + 1) % 8192;
    start = m_slot * 1024;
    if (m_armed && m_ctr == start) begin
      for (int c = 0; c < 4; c++) m_frame[c] = mk_frame(c);
    end
    if (m_armed && m_ctr >= start) begin
      ofs = m_ctr - start;
      if (ofs < 796) begin
        it.busy = 1'b1;
        if (ofs == 0) it.tag = "R6 R7";
        else if (ofs < 12) it.tag = "R8";
        else begin
          s = (ofs - 12) / 16; b = s / 4; ph = s % 4;
          it.tag = (b < 11) ? "R2 R3 R10" : (b == 11) ? "R5" : "R4";
          for (int c = 0; c < 4; c++) begin
            bv = (b < 11) ? m_frame[c][10-b] : (b == 11) ? ^m_frame[c] : 1'b0;
            it.pulse[c] = (ph == 0) || (ph == 2 && bv);
          end
        end
      end
    end
  endtask

  // driver: one tick, push the expected result, hand off to the monitor
  task automatic drive_tick();
    item_t it;
    @(negedge clk);
    tick = 1'b1;
    model_tick(it);
    sb.push_back(it);
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    -> chk_ev;
  endtask

  // monitor
  initial begin
    forever begin
      item_t e;
      @(chk_ev);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (busy_o !== e.busy || pulse_o !== e.pulse) begin
          fails++;
          $display("FAIL %s ctr=%0d: busy=%b pulse=%b expected busy=%b pulse=%b",
                   e.tag, m_ctr, busy_o, pulse_o, e.busy, e.pulse);
        end
      end
    end
  end

  // stimulus
  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (busy_o !== 1'b0 || pulse_o !== 4'h0) begin
      fails++;
      $display("FAIL R1 reset: busy=%b pulse=%b expected busy=0 pulse=0000", busy_o, pulse_o);
    end
    rst = 1'b0;
    payload_i = 16'hA5C3; unit_type_i = 1'b1; prog_chg_i = 1'b0; entropy_i = 4'h9;
    for (int t = 0; t < 5 * 8192 + 64; t++) begin
      drive_tick();
      if (m_ctr == 0) begin
        m_cyc++;
        entropy_i   = 4'(m_cyc * 5 + 3);
        payload_i   = (m_cyc % 2 == 1) ? 16'hF0E1 : 16'h0F7B;
        if (m_cyc == 3) payload_i = 16'hFFFF;
        if (m_cyc == 4) payload_i = 16'h0000;
        unit_type_i = m_cyc[0];
        prog_chg_i  = m_cyc[1];
      end
      if (m_armed && m_ctr == m_slot * 1024 + 100) begin
        // R10: disturb the inputs mid-transmission
        payload_i   = ~payload_i;
        unit_type_i = ~unit_type_i;
        prog_chg_i  = ~prog_chg_i;
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule